// File: doc/BRIEF.md
# SPI Register-Access Command Decoder

This block sits behind a byte-level SPI slave and turns the raw stream of received bytes into a small register protocol. Each received byte arrives with a one-cycle valid strobe. After that strobe the block presents the byte that the slave shifts out during the next byte slot. The first byte after selection is an opcode. One opcode returns an 8-bit status value. Two opcode ranges read or write one of sixteen 32-bit registers, with the register number in the low nibble. Register payloads travel most significant byte first.

Registers 0 to 3 are written by the master and driven out to user logic. Registers 4 to 15 are inputs from user logic that the master can only read. The active-low select line frames commands. Raising it cancels whatever command is in progress, and the next byte after reselection is decoded as an opcode.

Top module: `spi_regcmd_decoder`

## Requirements
- R1: After reset, `tx_byte` is 0x00 and all writable register outputs are zero.
- R2: The byte the master receives while it sends an opcode is 0x00.
- R3: Opcode 0x00 makes the following byte slot return `status_in` as sampled when the opcode arrived.
- R4: Opcode 0x8n returns register n over the next four byte slots, bits 31:24 first and bits 7:0 last. Registers 4 to 15 map to `ro_regs_in` bits [32*(n-4) +: 32].
- R5: Opcode 0xCn with n < 4 loads the next four received bytes into register n, first byte into bits 31:24, and drives it on `rw_regs_out` bits [32*n +: 32] once the fourth byte is in. The slave returns 0x00 during the data bytes.
- R6: Opcode 0xCn with n >= 4 consumes four data bytes and changes no register.
- R7: A write cut short by deselection leaves the target register unchanged.
- R8: Any opcode other than 0x00, 0x80–0x8F and 0xC0–0xCF is ignored and answered with 0x00. The next byte is decoded as a new opcode.
- R9: When all bytes of a command have been exchanged, the next received byte is decoded as an opcode without any deselection.
- R10: Deasserting select in the middle of a command returns the decoder to waiting for an opcode.
- R11: All four bytes of a register read come from the value sampled when the opcode arrived, even if the input changes during the read.
- R12: Received-byte strobes while select is deasserted are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_sel_n | input | 1 | Active-low select, already synchronized |
| rx_valid | input | 1 | One-cycle strobe: a byte has been received |
| rx_byte | input | 8 | Received byte, valid with `rx_valid` |
| tx_byte | output | 8 | Byte to shift out in the next byte slot |
| status_in | input | 8 | Status value from user logic |
| ro_regs_in | input | 384 | Read-only registers 4..15, 32 bits each |
| rw_regs_out | output | 128 | Writable registers 0..3, 32 bits each |

## Verification
Assertions check the following on every cycle:
- the decoder sits in the opcode phase after any deselected cycle;
- `tx_byte` is 0x00 whenever an opcode is expected;
- status is echoed one cycle after its opcode;
- the writable registers hold except on a commit that targets registers 0 to 3;
- the read snapshot holds between loads.

Only the bench scenarios show the rest:
- big-endian byte order;
- correct payloads across all sixteen registers;
- the sweep of all 256 opcode values;
- recovery after truncated commands;
- that a read returns old data while its source input changes.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned IDX_SPACE = 1 << IDX_W;

  typedef enum logic [1:0] {ST_CMD, ST_STAT, ST_READ, ST_WRITE} phase_e;
  typedef enum logic [1:0] {OP_NONE, OP_STAT, OP_READ, OP_WRITE} op_e;

  function automatic op_e classify(input logic [BYTE_W-1:0] b);
    if (b == 8'h00)          return OP_STAT;
    else if (b[7:4] == 4'h8) return OP_READ;
    else if (b[7:4] == 4'hC) return OP_WRITE;
    else                     return OP_NONE;
  endfunction
endpackage

// File: rtl/regcmd_seq.sv
module regcmd_seq
  import regcmd_pkg::*;
#(
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sel_n,
  input  logic                            rx_valid,
  input  logic [BYTE_W-1:0]               rx_byte,
  output phase_e                          phase,
  output logic [$clog2(WORD_BYTES)-1:0]   cnt,
  output logic                            last,
  output logic                            take,
  output logic                            stat_load,
  output logic                            rd_load,
  output logic                            rd_step,
  output logic                            wr_commit,
  output logic [IDX_W-1:0]                wr_idx,
  output logic [BYTE_W*WORD_BYTES-1:0]    wr_word
);
  localparam int unsigned CNT_W  = $clog2(WORD_BYTES);
  localparam int unsigned DATA_W = BYTE_W * WORD_BYTES;
  localparam int unsigned ACC_W  = DATA_W - BYTE_W;

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [ACC_W-1:0]   acc_q;
  op_e                op;
  logic               wr_start, wr_shift;

  assign take      = rx_valid && !sel_n;
  assign op        = classify(rx_byte);
  assign last      = (cnt_q == CNT_W'(WORD_BYTES - 1));
  assign stat_load = take && (phase_q == ST_CMD) && (op == OP_STAT);
  assign rd_load   = take && (phase_q == ST_CMD) && (op == OP_READ);
  assign wr_start  = take && (phase_q == ST_CMD) && (op == OP_WRITE);
  assign rd_step   = take && (phase_q == ST_READ);
  assign wr_shift  = take && (phase_q == ST_WRITE);
  assign wr_commit = wr_shift && last;
  assign wr_word   = {acc_q, rx_byte};
  assign wr_idx    = idx_q;
  assign phase     = phase_q;
  assign cnt       = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= ST_CMD;
      cnt_q   <= '0;
      idx_q   <= '0;
      acc_q   <= '0;
    end else if (sel_n) begin
      phase_q <= ST_CMD;
      cnt_q   <= '0;
    end else if (take) begin
      case (phase_q)
        ST_CMD: begin
          cnt_q <= '0;
          idx_q <= rx_byte[IDX_W-1:0];
          if (stat_load)     phase_q <= ST_STAT;
          else if (rd_load)  phase_q <= ST_READ;
          else if (wr_start) phase_q <= ST_WRITE;
        end
        ST_STAT: phase_q <= ST_CMD;
        ST_READ, ST_WRITE: begin
          if (phase_q == ST_WRITE)
            acc_q <= {acc_q[ACC_W-BYTE_W-1:0], rx_byte};
          if (last) begin
            phase_q <= ST_CMD;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= ST_CMD;
      endcase
    end
  end

  // R10: a deselected cycle always leaves the sequencer waiting for an opcode
  p_deselect_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (phase_q == ST_CMD));

  // R9: at most one protocol event per cycle
  p_single_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stat_load, rd_load, wr_start, rd_step, wr_shift}));

  // R12: nothing moves while deselected
  p_ignore_deselected_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && rx_valid) |=> $stable(acc_q));
endmodule

// File: rtl/regcmd_regs.sv
module regcmd_regs
  import regcmd_pkg::*;
#(
  parameter int unsigned NUM_RW = 4,
  parameter int unsigned NUM_RO = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_commit,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [IDX_W-1:0]         rd_idx,
  input  logic [NUM_RO*DATA_W-1:0] ro_in,
  output logic [NUM_RW*DATA_W-1:0] rw_out,
  output logic [DATA_W-1:0]        rd_word
);
  localparam int unsigned NUM_REGS = NUM_RW + NUM_RO;

  logic [DATA_W-1:0] all_w [IDX_SPACE];
  logic              wr_allowed;

  assign wr_allowed = wr_commit && (32'(wr_idx) < NUM_RW);

  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    logic [DATA_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        val_q <= '0;
      else if (wr_allowed && (wr_idx == IDX_W'(g)))
        val_q <= wr_data;
    end
    assign all_w[g] = val_q;
    assign rw_out[g*DATA_W +: DATA_W] = val_q;
  end

  for (genvar g = 0; g < NUM_RO; g++) begin : g_ro
    assign all_w[NUM_RW+g] = ro_in[g*DATA_W +: DATA_W];
  end

  for (genvar g = NUM_REGS; g < IDX_SPACE; g++) begin : g_hole
    assign all_w[g] = '0;
  end

  assign rd_word = all_w[rd_idx];

  // R7: writable registers change only on a committed write
  p_rw_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(rw_out));

  // R6: a commit aimed at a read-only slot leaves every writable register alone
  p_ro_write_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && (32'(wr_idx) >= NUM_RW)) |=> $stable(rw_out));
endmodule

// File: rtl/regcmd_txq.sv
module regcmd_txq
  import regcmd_pkg::*;
#(
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sel_n,
  input  logic                          take,
  input  logic                          stat_load,
  input  logic [BYTE_W-1:0]             status_in,
  input  logic                          rd_load,
  input  logic [BYTE_W*WORD_BYTES-1:0]  rd_word,
  input  logic                          rd_step,
  input  logic                          last,
  input  logic [$clog2(WORD_BYTES)-1:0] cnt,
  output logic [BYTE_W-1:0]             tx_byte
);
  localparam int unsigned DATA_W = BYTE_W * WORD_BYTES;

  logic [DATA_W-1:0] snap_q;
  logic [BYTE_W-1:0] tx_q;

  function automatic logic [BYTE_W-1:0] byte_at(input logic [DATA_W-1:0] w,
                                                input int unsigned k);
    return w[DATA_W-1-BYTE_W*k -: BYTE_W];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q   <= '0;
      snap_q <= '0;
    end else begin
      if (rd_load) snap_q <= rd_word;
      if (sel_n)          tx_q <= '0;
      else if (stat_load) tx_q <= status_in;
      else if (rd_load)   tx_q <= byte_at(rd_word, 0);
      else if (rd_step)   tx_q <= last ? '0 : byte_at(snap_q, int'(cnt) + 1);
      else if (take)      tx_q <= '0;
    end
  end

  assign tx_byte = tx_q;

  // R11: the read snapshot is frozen between opcode loads
  p_snap_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_load |=> $stable(snap_q));
endmodule

// File: rtl/spi_regcmd_decoder.sv
module spi_regcmd_decoder
  import regcmd_pkg::*;
#(
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned NUM_RW     = 4,
  parameter int unsigned NUM_RO     = 12
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 chip_sel_n,
  input  logic                                 rx_valid,
  input  logic [7:0]                           rx_byte,
  output logic [7:0]                           tx_byte,
  input  logic [7:0]                           status_in,
  input  logic [NUM_RO*BYTE_W*WORD_BYTES-1:0]  ro_regs_in,
  output logic [NUM_RW*BYTE_W*WORD_BYTES-1:0]  rw_regs_out
);
  localparam int unsigned DATA_W = BYTE_W * WORD_BYTES;
  localparam int unsigned CNT_W  = $clog2(WORD_BYTES);

  phase_e             phase;
  logic [CNT_W-1:0]   cnt;
  logic               last, take, stat_load, rd_load, rd_step, wr_commit;
  logic [IDX_W-1:0]   wr_idx;
  logic [DATA_W-1:0]  wr_word, rd_word;

  regcmd_seq #(.WORD_BYTES(WORD_BYTES)) seq_i (
    .clk(clk), .rst_n(rst_n), .sel_n(chip_sel_n), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .phase(phase), .cnt(cnt), .last(last), .take(take),
    .stat_load(stat_load), .rd_load(rd_load), .rd_step(rd_step),
    .wr_commit(wr_commit), .wr_idx(wr_idx), .wr_word(wr_word)
  );

  regcmd_regs #(.NUM_RW(NUM_RW), .NUM_RO(NUM_RO), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .wr_idx(wr_idx),
    .wr_data(wr_word), .rd_idx(rx_byte[IDX_W-1:0]), .ro_in(ro_regs_in),
    .rw_out(rw_regs_out), .rd_word(rd_word)
  );

  regcmd_txq #(.WORD_BYTES(WORD_BYTES)) txq_i (
    .clk(clk), .rst_n(rst_n), .sel_n(chip_sel_n), .take(take),
    .stat_load(stat_load), .status_in(status_in), .rd_load(rd_load),
    .rd_word(rd_word), .rd_step(rd_step), .last(last), .cnt(cnt),
    .tx_byte(tx_byte)
  );

  // R2 / R8: whenever an opcode is awaited the outgoing byte is zero
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_CMD) |-> (tx_byte == 8'h00));

  // R3: the status opcode echoes the status input on the next cycle
  p_status_echo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_load |=> (tx_byte == $past(status_in)));
endmodule

// File: tb/spi_regcmd_decoder_tb.sv
`timescale 1ns/1ps
module spi_regcmd_decoder_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         chip_sel_n = 1'b1;
  logic         rx_valid = 1'b0;
  logic [7:0]   rx_byte = 8'h00;
  logic [7:0]   tx_byte;
  logic [7:0]   status_in = 8'h00;
  logic [383:0] ro_regs_in;
  logic [127:0] rw_regs_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] model_rw [4];

  always #4 clk = ~clk;

  spi_regcmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_byte(tx_byte), .status_in(status_in),
    .ro_regs_in(ro_regs_in), .rw_regs_out(rw_regs_out)
  );

  function automatic logic [31:0] ro_val(input int r, input int salt);
    return {8'(r * 17 + salt), 8'(r ^ 8'h5A), 8'(255 - r), 8'(salt + 3 * r)};
  endfunction

  function automatic logic [31:0] wr_val(input int r);
    return 32'h9E3779B9 * 32'(r + 1);
  endfunction

  function automatic bit is_known_op(input int b);
    return (b == 0) || (b >= 8'h80 && b <= 8'h8F) || (b >= 8'hC0 && b <= 8'hCF);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] got);
    @(negedge clk);
    got = tx_byte;
    rx_byte = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic select();
    @(negedge clk); chip_sel_n = 1'b0; @(negedge clk);
  endtask

  task automatic deselect();
    @(negedge clk); chip_sel_n = 1'b1; @(negedge clk); @(negedge clk);
  endtask

  task automatic write_reg(input int r, input logic [31:0] v, input string req);
    logic [7:0] got;
    xfer(8'hC0 | 8'(r), got);
    check({req, " opcode reply"}, 32'(got), 32'h0);
    for (int k = 0; k < 4; k++) begin
      xfer(v[31-8*k -: 8], got);
      check({req, " data-byte reply"}, 32'(got), 32'h0);
    end
  endtask

  task automatic read_reg(input int r, input logic [31:0] exp, input string req);
    logic [7:0] got;
    logic [31:0] word;
    xfer(8'h80 | 8'(r), got);
    check("R2 read opcode reply", 32'(got), 32'h0);
    for (int k = 0; k < 4; k++) begin
      xfer(8'hFF, got);
      word[31-8*k -: 8] = got;
    end
    check(req, word, exp);
  endtask

  task automatic check_rw(input string req);
    for (int r = 0; r < 4; r++)
      check(req, rw_regs_out[32*r +: 32], model_rw[r]);
  endtask

  initial begin
    for (int j = 0; j < 12; j++) ro_regs_in[32*j +: 32] = ro_val(j + 4, 1);
    for (int r = 0; r < 4; r++) model_rw[r] = 32'h0;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset tx", 32'(tx_byte), 32'h0);
    check_rw("R1 reset regs");

    select();
    // R5 / R9: back-to-back writes to every writable register
    for (int r = 0; r < 4; r++) begin
      write_reg(r, wr_val(r), "R5");
      model_rw[r] = wr_val(r);
      check("R5 output after write", rw_regs_out[32*r +: 32], model_rw[r]);
    end
    check_rw("R5 all writable");

    // R6: writes aimed at read-only slots
    for (int r = 4; r < 16; r++) begin
      write_reg(r, 32'hDEADBEEF, "R6");
      check_rw("R6 writable untouched");
    end

    // R4: read back all sixteen registers, MSB first
    for (int r = 0; r < 16; r++)
      read_reg(r, r < 4 ? model_rw[r] : ro_val(r, 1), "R4 register readback");

    // R3: status sweep
    for (int k = 0; k < 8; k++) begin
      status_in = 8'(8'h3C ^ (k * 37));
      xfer(8'h00, got);
      check("R2 status opcode reply", 32'(got), 32'h0);
      xfer(8'hAA, got);
      check("R3 status value", 32'(got), 32'(8'(8'h3C ^ (k * 37))));
    end

    // R8 / R9: every unrecognised opcode, then a status command must decode
    status_in = 8'h96;
    for (int b = 0; b < 256; b++) begin
      if (!is_known_op(b)) begin
        xfer(8'(b), got);
        check("R8 unknown opcode reply", 32'(got), 32'h0);
        xfer(8'h00, got);
        check("R8 reply after unknown opcode", 32'(got), 32'h0);
        xfer(8'h11, got);
        check("R9 following opcode decoded", 32'(got), 32'h96);
      end
    end

    // R7: truncated write
    xfer(8'hC1, got);
    xfer(8'h12, got);
    xfer(8'h34, got);
    deselect();
    select();
    check_rw("R7 truncated write");
    read_reg(1, model_rw[1], "R7 readback after truncation");

    // R10: abort mid-read, then a fresh status command works
    xfer(8'h87, got);
    xfer(8'hFF, got);
    xfer(8'hFF, got);
    deselect();
    check("R10 tx quiet when deselected", 32'(tx_byte), 32'h0);
    select();
    status_in = 8'h5E;
    xfer(8'h00, got);
    check("R10 opcode reply after abort", 32'(got), 32'h0);
    xfer(8'h00, got);
    check("R10 status after abort", 32'(got), 32'h5E);

    // R11: snapshot survives an input change mid-read
    begin
      logic [31:0] word;
      xfer(8'h8A, got);
      ro_regs_in[32*6 +: 32] = ro_val(10, 77);
      for (int k = 0; k < 4; k++) begin
        xfer(8'hFF, got);
        word[31-8*k -: 8] = got;
      end
      check("R11 snapshot value", word, ro_val(10, 1));
      read_reg(10, ro_val(10, 77), "R11 new value on next read");
    end

    // R12: strobes while deselected are ignored
    deselect();
    xfer(8'hC2, got);
    for (int k = 0; k < 4; k++) xfer(8'h00, got);
    check("R12 tx while deselected", 32'(tx_byte), 32'h0);
    check_rw("R12 writable untouched");
    select();
    read_reg(2, model_rw[2], "R12 readback");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule